// File: doc/BRIEF.md
# Power-Fail Access and Backup Supervisor

This block is the digital half of a supply supervisor for a battery-backed memory with a timekeeper. Analog comparators report whether the main supply sits above the write-protect threshold and above the battery-switch threshold. A third input reports which of those two thresholds is the lower one. The block turns these three bits into four outputs: an access enable that deselects the memory and the clock, an active-low reset output, a supply select (main or battery), and a battery-connect latch. The power switches that these outputs steer are outside the block.

A fresh part keeps its battery isolated until the supply first climbs above the write-protect threshold. From that point the battery stays connected. Whenever the supply sags below the write-protect threshold, every access is blocked and reset is driven. Once the supply returns, reset is held for a recovery interval. A counter on the slow timekeeping clock measures this interval, and the counter starts over if the supply dips again before the interval ends. The handover to the battery happens at whichever threshold is lower.

Top module: `psu_guard`

## Requirements
- R1: Once `rst_n` has been released and no threshold input has been seen high, all four outputs are 0.
- R2: Before the first rise of `vcc_above_wp`, `bat_connected` and `supply_sel` stay 0 whatever `vcc_above_sw` and `vbat_above_wp` do.
- R3: `bat_connected` becomes 1 on the third rising `clk` edge after `vcc_above_wp` first goes high. It then stays 1 until `rst_n` is asserted. `supply_sel` is never 1 while `bat_connected` is 0.
- R4: `access_en` is 1 only when the supervisor is in normal operation. It is 0 in every cycle after the synchronized `vcc_above_wp` is seen low.
- R5: After `vcc_above_wp` rises and stays high (with no battery condition), `rst_out_n` is 0 through the (REC_CYCLES+2)-th rising edge. It goes to 1, together with `access_en`, on the (REC_CYCLES+3)-th rising edge.
- R6: If `vcc_above_wp` falls during the recovery interval, the interval is discarded. After the next rise, the full R5 timing applies again from the start.
- R7: Switch point. When `vbat_above_wp` is 1, the write-protect threshold is the lower one, and the battery is selected while `vcc_above_wp` is 0. When `vbat_above_wp` is 0, the battery is selected while `vcc_above_sw` is 0. `supply_sel` = 1 means battery and 0 means main.
- R8: While `supply_sel` is 1, `access_en` is 0 and `rst_out_n` is 0.
- R9: All threshold inputs pass through a two-stage synchronizer. After `vcc_above_wp` falls, `access_en` is still 1 after two rising edges and is 0 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor |
| vcc_above_wp | input | 1 | Comparator: supply above write-protect threshold |
| vcc_above_sw | input | 1 | Comparator: supply above battery-switch threshold |
| vbat_above_wp | input | 1 | Comparator: 1 when the write-protect threshold is the lower switch point |
| access_en | output | 1 | 1 allows memory and clock access; 0 deselects both |
| rst_out_n | output | 1 | Active-low reset output to the system |
| supply_sel | output | 1 | 0 selects main supply, 1 selects battery |
| bat_connected | output | 1 | One-time battery-connect latch |

## Verification
The assertions assume that the comparator bits come from slowly moving analog levels. Each level is therefore expected to last at least as long as the synchronizer depth before it changes again. The recovery check also assumes that the synchronized write-protect bit is the only thing that ends a recovery count. The stimulus respects this: every directed level is held for several clock cycles, and every random level is held for the recovery length plus a margin before it is compared with the steady-state outputs that the bench computes from the three input bits and the latch history.

// File: rtl/psu_pkg.sv
package psu_pkg;

    typedef enum logic [2:0] {
        ST_FRESH   = 3'd0,
        ST_ACTIVE  = 3'd1,
        ST_PROTECT = 3'd2,
        ST_BACKUP  = 3'd3,
        ST_RECOVER = 3'd4
    } psu_state_e;

    typedef struct packed {
        psu_state_e st;
        logic       conn;
        logic       acc;
        logic       rstn;
        logic       sel;
    } psu_ctrl_t;

endpackage

// File: rtl/psu_sync.sv
module psu_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb pipe_d[g] = din;
            end else begin : g_next
                always_comb pipe_d[g] = pipe_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/psu_rec_timer.sv
module psu_rec_timer #(
    parameter int REC_CYCLES = 1147
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CNT_W = $clog2(REC_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/psu_ctrl.sv
module psu_ctrl
    import psu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wp_ok,
    input  logic      sw_ok,
    input  logic      wp_is_lower,
    input  logic      rec_done,
    output logic      in_recover,
    output psu_ctrl_t ctrl
);

    psu_ctrl_t ctrl_d, ctrl_q;
    logic      below_switch;
    psu_state_e powered_next;

    always_comb begin
        below_switch = wp_is_lower ? !wp_ok : !sw_ok;

        if (below_switch)                                 powered_next = ST_BACKUP;
        else if (!wp_ok)                                  powered_next = ST_PROTECT;
        else if (ctrl_q.st == ST_ACTIVE)                  powered_next = ST_ACTIVE;
        else if (ctrl_q.st == ST_RECOVER && rec_done)     powered_next = ST_ACTIVE;
        else                                              powered_next = ST_RECOVER;

        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            ST_FRESH: begin
                if (wp_ok) begin
                    ctrl_d.st   = ST_RECOVER;
                    ctrl_d.conn = 1'b1;
                end
            end
            ST_ACTIVE, ST_PROTECT, ST_BACKUP, ST_RECOVER: ctrl_d.st = powered_next;
            default: ctrl_d.st = ST_PROTECT;
        endcase

        ctrl_d.acc  = (ctrl_d.st == ST_ACTIVE);
        ctrl_d.rstn = (ctrl_d.st == ST_ACTIVE);
        ctrl_d.sel  = (ctrl_d.st == ST_BACKUP) && ctrl_d.conn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{st: ST_FRESH, conn: 1'b0, acc: 1'b0, rstn: 1'b0, sel: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign in_recover = (ctrl_q.st == ST_RECOVER);
    assign ctrl       = ctrl_q;

endmodule

// File: rtl/psu_guard.sv
module psu_guard
    import psu_pkg::*;
#(
    parameter int REC_CYCLES  = 1147,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_above_wp,
    input  logic vcc_above_sw,
    input  logic vbat_above_wp,
    output logic access_en,
    output logic rst_out_n,
    output logic supply_sel,
    output logic bat_connected
);

    localparam int NUM_CMP = 3;

    logic [NUM_CMP-1:0] cmp_s;
    logic               wp_s, sw_s, lower_s;
    logic               rec_run, rec_done;
    psu_ctrl_t          ctrl;

    psu_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({vbat_above_wp, vcc_above_sw, vcc_above_wp}),
        .dout  (cmp_s)
    );

    assign wp_s    = cmp_s[0];
    assign sw_s    = cmp_s[1];
    assign lower_s = cmp_s[2];

    psu_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rec_run),
        .done  (rec_done)
    );

    psu_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wp_ok       (wp_s),
        .sw_ok       (sw_s),
        .wp_is_lower (lower_s),
        .rec_done    (rec_done),
        .in_recover  (rec_run),
        .ctrl        (ctrl)
    );

    assign access_en     = ctrl.acc;
    assign rst_out_n     = ctrl.rstn;
    assign supply_sel    = ctrl.sel;
    assign bat_connected = ctrl.conn;

endmodule

// File: rtl/psu_guard_chk.sv
module psu_guard_chk #(
    parameter int REC_CYCLES = 1147
) (
    input logic clk,
    input logic rst_n,
    input logic wp_s,
    input logic access_en,
    input logic rst_out_n,
    input logic supply_sel,
    input logic bat_connected
);

    localparam int HW = $clog2(REC_CYCLES + 2);
    localparam logic [HW-1:0] SAT = HW'(REC_CYCLES + 1);

    logic [HW-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_cnt_q <= '0;
        else if (!wp_s)          hi_cnt_q <= '0;
        else if (hi_cnt_q != SAT) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assert_fresh_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bat_connected |-> (!access_en && !supply_sel));

    assert_latch_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bat_connected |=> bat_connected);

    assert_sel_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        supply_sel |-> bat_connected);

    assert_blocked_low_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_s |=> !access_en);

    assert_recovery_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (hi_cnt_q >= HW'(REC_CYCLES)));

    assert_backup_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_sel |-> (!access_en && !rst_out_n));

endmodule

bind psu_guard psu_guard_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wp_s          (wp_s),
    .access_en     (access_en),
    .rst_out_n     (rst_out_n),
    .supply_sel    (supply_sel),
    .bat_connected (bat_connected)
);

// File: tb/psu_guard_tb.sv
module psu_guard_tb;

    localparam int REC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp = 1'b0, sw = 1'b0, lower = 1'b0;
    logic access_en, rst_out_n, supply_sel, bat_connected;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    psu_guard #(.REC_CYCLES(REC)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .vcc_above_wp  (wp),
        .vcc_above_sw  (sw),
        .vbat_above_wp (lower),
        .access_en     (access_en),
        .rst_out_n     (rst_out_n),
        .supply_sel    (supply_sel),
        .bat_connected (bat_connected)
    );

    // expected {access_en, rst_out_n, supply_sel, bat_connected} after inputs settle
    function automatic logic [3:0] steady(input logic conn, input logic w, input logic s, input logic l);
        logic below;
        below = l ? !w : !s;
        if (!conn)      return 4'b0000;
        else if (below) return 4'b0011;
        else if (!w)    return 4'b0001;
        else            return 4'b1101;
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {access_en, rst_out_n, supply_sel, bat_connected};
    endfunction

    task automatic drive(input logic w, input logic s, input logic l);
        @(negedge clk);
        wp = w; sw = s; lower = l;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wp = 1'b0; sw = 1'b0; lower = 1'b0;
        edges(2);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic conn_m;
        void'($urandom(32'h5EED_1234));
        do_reset();
        edges(3);
        check("R1 reset state", outs(), 4'b0000);

        // R2: fresh part, battery inputs wiggle, wp stays low
        drive(1'b0, 1'b0, 1'b0); edges(6);
        check("R2 fresh sw low", outs(), 4'b0000);
        drive(1'b0, 1'b1, 1'b1); edges(6);
        check("R2 fresh lower set", outs(), 4'b0000);

        // R3 / R5: first power-up
        drive(1'b1, 1'b1, 1'b1);
        edges(2);
        check("R3 latch not yet", outs(), 4'b0000);
        edges(1);
        check("R3 latch set", outs(), 4'b0001);
        edges(REC - 1);
        check("R5 reset held", outs(), 4'b0001);
        edges(1);
        check("R5 reset released", outs(), 4'b1101);

        // R9 / R4: supply drop goes through two sync stages
        drive(1'b0, 1'b1, 1'b1);
        edges(2);
        check("R9 still active", outs(), 4'b1101);
        edges(1);
        check("R4 access blocked", outs(), 4'b0011);
        drive(1'b0, 1'b1, 1'b0); edges(4);
        check("R4 protect, latch kept R3", outs(), 4'b0001);

        // R6: drop during recovery restarts the count
        drive(1'b1, 1'b1, 1'b0);
        edges(10);
        check("R6 mid recovery", outs(), 4'b0001);
        drive(1'b0, 1'b1, 1'b0); edges(4);
        drive(1'b1, 1'b1, 1'b0);
        edges(REC + 2);
        check("R6 restarted count holds reset", outs(), 4'b0001);
        edges(1);
        check("R6 released after full count", outs(), 4'b1101);

        // R7 / R8: switch-point selection
        drive(1'b1, 1'b0, 1'b1); edges(6);
        check("R7 wp lower, supply ok", outs(), 4'b1101);
        drive(1'b1, 1'b0, 1'b0); edges(6);
        check("R7 R8 sw lower, on battery", outs(), 4'b0011);
        drive(1'b0, 1'b1, 1'b0); edges(6);
        check("R7 sw lower, above sw stays main", outs(), 4'b0001);
        drive(1'b0, 1'b1, 1'b1); edges(6);
        check("R7 R8 wp lower, below wp on battery", outs(), 4'b0011);

        // random steady-state levels with occasional fresh restarts
        conn_m = 1'b1;
        for (int i = 0; i < 60; i++) begin
            logic w, s, l;
            if (i % 15 == 0) begin
                do_reset();
                conn_m = 1'b0;
            end
            w = ($urandom % 3) == 0;
            s = $urandom % 2;
            l = $urandom % 2;
            drive(w, s, l);
            if (w) conn_m = 1'b1;
            edges(REC + 8);
            check("R2/R3/R4/R7/R8 random", outs(), steady(conn_m, w, s, l));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule